// File: doc/BRIEF.md
# Audio Path Activity Controller

This block is the control and buffering core of a stereo audio serial port that carries three data paths: a primary transmit path, a secondary transmit path that overlays the first on the same transmit channel, and one receive path. Software writes an active bit and a pause bit for each path. From these bits the block derives a global enable, a pause for each serial channel and a 2-bit operating mode, and it registers all of them.

The block also holds one FIFO for each path. Each FIFO has its own flush control and a fill count that software can read. On the system side, software or a DMA engine pushes transmit words and pops receive words through strobes. On the line side, the serializer pops transmit words and pushes receive words. The serializer and the clocking are outside this block. Both transmit paths feed the one transmit channel, so that channel pauses only after both transmit paths have stopped.

Top module: `audio_path_ctrl`

## Requirements
- R1: After reset all path bits, flush bits, counts and sticky flags are zero. `glob_en` is 0, `op_mode` is 00, and both `tx_ch_pause` and `rx_ch_pause` are 1. Address 0 reads 32'h0000_0600.
- R2: A path runs when its active bit is 1 and its pause bit is 0. While either transmit path runs, `glob_en` is 1 and `tx_ch_pause` is 0. These outputs take their new values on the same clock edge that accepts the register write.
- R3: The transmit channel stays unpaused while at least one transmit path runs, whatever the state of the other transmit path.
- R4: When no transmit path runs, `tx_ch_pause` is 1. If the receive path still runs, `op_mode` is receive-only. If no path runs, `glob_en` is 0 and `op_mode` is 00.
- R5: `op_mode` uses three codes: 00 means transmit only, 01 means receive only and 10 means transmit plus receive. Code 10 is selected whenever a transmit path and the receive path run together. Code 11 never appears.
- R6: `rx_ch_pause` is 1 exactly when the receive path is not running.
- R7: Address 0 holds the main control bits. Bit 0 is primary active, bit 1 primary pause, bit 2 secondary active, bit 3 secondary pause, bit 4 receive active, bit 5 receive pause, bit 6 primary transmit flush and bit 7 receive flush. Bits 8, 9, 10 and 13:12 read back `glob_en`, `tx_ch_pause`, `rx_ch_pause` and `op_mode`. Address 1 bit 0 is the secondary transmit flush. Address 2 is status: bits 4:0 primary count, bits 12:8 secondary count, bits 20:16 receive count, bit 24 primary overflow, bit 25 secondary overflow and bit 26 receive underflow.
- R8: A FIFO flush empties that FIFO in the clock cycle after the flush bit is first sampled high. The FIFO stays empty while the bit remains set. Pushes made during a flush are dropped without setting a flag.
- R9: Each flush bit affects only its own FIFO. The counts of the other FIFOs do not change.
- R10: Each FIFO holds 16 words of 32 bits and returns them in the order written. Its count runs from 0 to 16.
- R11: A push into a full transmit FIFO is ignored: the count stays at 16 and the stored words are unchanged. It also sets that FIFO's sticky overflow flag, which stays set until reset.
- R12: A pop from the empty receive FIFO is ignored and sets the sticky underflow flag. Receive words come out in arrival order on `rx_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| txp_push | input | 1 | Push into primary transmit FIFO |
| txp_wdata | input | 32 | Primary transmit word |
| txs_push | input | 1 | Push into secondary transmit FIFO |
| txs_wdata | input | 32 | Secondary transmit word |
| rx_pop | input | 1 | Pop from receive FIFO |
| rx_rdata | output | 32 | Head of receive FIFO |
| ser_txp_pop | input | 1 | Serializer pop, primary transmit FIFO |
| ser_txp_data | output | 32 | Head of primary transmit FIFO |
| ser_txs_pop | input | 1 | Serializer pop, secondary transmit FIFO |
| ser_txs_data | output | 32 | Head of secondary transmit FIFO |
| ser_rx_push | input | 1 | Serializer push into receive FIFO |
| ser_rx_data | input | 32 | Received word |
| glob_en | output | 1 | Global enable |
| op_mode | output | 2 | Operating mode |
| tx_ch_pause | output | 1 | Transmit channel pause |
| rx_ch_pause | output | 1 | Receive channel pause |

## Verification
The mode derivation is driven with a table of control-word patterns. The table covers each transmit path running alone, both transmit paths together, one transmit path paused while the other runs, receive alone, receive combined with each transmit path, and receive paused. These patterns separate a transmit channel that wrongly pauses on one stopped path from one that correctly pauses only when no transmit path runs. They also separate the duplex code from the two single-direction codes. Directed sequences then fill a transmit FIFO past full, check the word order, and time each flush to the exact cycle it takes effect. Those sequences also confirm that each flush leaves the other FIFOs untouched and that the receive FIFO underflows on an empty pop.

// File: rtl/apc_pkg.sv
package apc_pkg;
    typedef enum logic [1:0] {
        MODE_TX     = 2'b00,
        MODE_RX     = 2'b01,
        MODE_DUPLEX = 2'b10
    } op_mode_e;

    // bit 0 = primary active ... bit 5 = receive pause
    typedef struct packed {
        logic rx_pause;
        logic rx_act;
        logic sec_pause;
        logic sec_act;
        logic pri_pause;
        logic pri_act;
    } path_bits_t;

    localparam logic [1:0] ADDR_MAIN   = 2'd0;
    localparam logic [1:0] ADDR_SEC    = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
    localparam int         NUM_FIFOS   = 3;
endpackage

// File: rtl/apc_fifo.sv
module apc_fifo #(
    parameter int W           = 32,
    parameter int DEPTH       = 16,
    parameter bit FLAG_ON_POP = 1'b0,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          drop
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop, is_full, is_empty;

    always_comb begin
        is_full  = (st_q.cnt == CW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_push  = push && !is_full && !flush;
        do_pop   = pop && !is_empty && !flush;
        st_d     = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = st_q.wptr + AW'(1);
            if (do_pop)  st_d.rptr = st_q.rptr + AW'(1);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= wdata;
    end

    generate
        if (FLAG_ON_POP) begin : g_pop_flag
            assign drop = pop && is_empty && !flush;
        end else begin : g_push_flag
            assign drop = push && is_full && !flush;
        end
    endgenerate

    assign rdata = mem[st_q.rptr];
    assign count = st_q.cnt;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R8
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R10
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !pop && !flush) |=> (count == CW'(DEPTH))); // R11
endmodule

// File: rtl/apc_path_ctrl.sv
module apc_path_ctrl
    import apc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [1:0]           addr,
    input  logic [7:0]           wdata,
    input  logic [NUM_FIFOS-1:0] drop_evt,
    output path_bits_t           paths,
    output logic [NUM_FIFOS-1:0] flush,
    output logic [NUM_FIFOS-1:0] flags,
    output logic                 glob_en,
    output op_mode_e             mode,
    output logic                 tx_pause,
    output logic                 rx_pause
);
    typedef struct packed {
        path_bits_t            paths;
        logic [NUM_FIFOS-1:0]  flush;   // 0 primary, 1 secondary, 2 receive
        logic [NUM_FIFOS-1:0]  flags;
        logic                  glob_en;
        op_mode_e              mode;
        logic                  tx_pause;
        logic                  rx_pause;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic tx_run, rx_run;

    always_comb begin
        st_d = st_q;
        if (we && addr == ADDR_MAIN) begin
            st_d.paths    = path_bits_t'(wdata[5:0]);
            st_d.flush[0] = wdata[6];
            st_d.flush[2] = wdata[7];
        end
        if (we && addr == ADDR_SEC) begin
            st_d.flush[1] = wdata[0];
        end
        tx_run = (st_d.paths.pri_act && !st_d.paths.pri_pause) ||
                 (st_d.paths.sec_act && !st_d.paths.sec_pause);
        rx_run = st_d.paths.rx_act && !st_d.paths.rx_pause;
        st_d.glob_en  = tx_run || rx_run;
        st_d.tx_pause = !tx_run;
        st_d.rx_pause = !rx_run;
        if (tx_run && rx_run) st_d.mode = MODE_DUPLEX;
        else if (rx_run)      st_d.mode = MODE_RX;
        else                  st_d.mode = MODE_TX;
        st_d.flags = st_q.flags | drop_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_TX;
            st_q.tx_pause <= 1'b1;
            st_q.rx_pause <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign paths    = st_q.paths;
    assign flush    = st_q.flush;
    assign flags    = st_q.flags;
    assign glob_en  = st_q.glob_en;
    assign mode     = st_q.mode;
    assign tx_pause = st_q.tx_pause;
    assign rx_pause = st_q.rx_pause;

    AST_TX_RUN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_pause |-> glob_en); // R2
    AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (tx_pause && rx_pause && mode == MODE_TX)); // R4
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != op_mode_e'(2'b11)); // R5
    AST_DUPLEX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_pause && !rx_pause) |-> (mode == MODE_DUPLEX)); // R5
    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags)) == $past(flags))); // R11
endmodule

// File: rtl/audio_path_ctrl.sv
module audio_path_ctrl
    import apc_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [7:0]   reg_wdata,
    output logic [31:0]  reg_rdata,
    input  logic         txp_push,
    input  logic [W-1:0] txp_wdata,
    input  logic         txs_push,
    input  logic [W-1:0] txs_wdata,
    input  logic         rx_pop,
    output logic [W-1:0] rx_rdata,
    input  logic         ser_txp_pop,
    output logic [W-1:0] ser_txp_data,
    input  logic         ser_txs_pop,
    output logic [W-1:0] ser_txs_data,
    input  logic         ser_rx_push,
    input  logic [W-1:0] ser_rx_data,
    output logic         glob_en,
    output logic [1:0]   op_mode,
    output logic         tx_ch_pause,
    output logic         rx_ch_pause
);
    path_bits_t           paths;
    logic [NUM_FIFOS-1:0] flush, flags, drop_evt;
    op_mode_e             mode;
    logic [CW-1:0]        cnt [NUM_FIFOS];

    apc_path_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .drop_evt (drop_evt),
        .paths    (paths),
        .flush    (flush),
        .flags    (flags),
        .glob_en  (glob_en),
        .mode     (mode),
        .tx_pause (tx_ch_pause),
        .rx_pause (rx_ch_pause)
    );

    apc_fifo #(.W(W), .DEPTH(DEPTH), .FLAG_ON_POP(1'b0)) u_txp_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush[0]),
        .push(txp_push), .wdata(txp_wdata), .pop(ser_txp_pop),
        .rdata(ser_txp_data), .count(cnt[0]), .drop(drop_evt[0])
    );

    apc_fifo #(.W(W), .DEPTH(DEPTH), .FLAG_ON_POP(1'b0)) u_txs_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush[1]),
        .push(txs_push), .wdata(txs_wdata), .pop(ser_txs_pop),
        .rdata(ser_txs_data), .count(cnt[1]), .drop(drop_evt[1])
    );

    apc_fifo #(.W(W), .DEPTH(DEPTH), .FLAG_ON_POP(1'b1)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush[2]),
        .push(ser_rx_push), .wdata(ser_rx_data), .pop(rx_pop),
        .rdata(rx_rdata), .count(cnt[2]), .drop(drop_evt[2])
    );

    assign op_mode = mode;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_MAIN: begin
                reg_rdata[5:0]   = paths;
                reg_rdata[6]     = flush[0];
                reg_rdata[7]     = flush[2];
                reg_rdata[8]     = glob_en;
                reg_rdata[9]     = tx_ch_pause;
                reg_rdata[10]    = rx_ch_pause;
                reg_rdata[13:12] = mode;
            end
            ADDR_SEC:    reg_rdata[0] = flush[1];
            ADDR_STATUS: begin
                for (int i = 0; i < NUM_FIFOS; i++) begin
                    reg_rdata[i*8 +: CW] = cnt[i];
                end
                reg_rdata[26:24] = flags;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/audio_path_ctrl_test.sv
module audio_path_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txp_push = 1'b0, txs_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] txp_wdata = '0, txs_wdata = '0, rx_rdata;
    logic        ser_txp_pop = 1'b0, ser_txs_pop = 1'b0, ser_rx_push = 1'b0;
    logic [31:0] ser_txp_data, ser_txs_data, ser_rx_data = '0;
    logic        glob_en, tx_ch_pause, rx_ch_pause;
    logic [1:0]  op_mode;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audio_path_ctrl uut (.*);

    // {rx_pause, tx_pause, mode[1:0], glob_en, ctrl[5:0]}
    localparam logic [10:0] VEC [10] = '{
        {1'b1, 1'b0, 2'b00, 1'b1, 6'b000001},  // R2 primary alone
        {1'b1, 1'b0, 2'b00, 1'b1, 6'b000100},  // R3 secondary alone
        {1'b1, 1'b0, 2'b00, 1'b1, 6'b000101},  // R2 both transmit
        {1'b1, 1'b0, 2'b00, 1'b1, 6'b000111},  // R3 primary paused
        {1'b1, 1'b1, 2'b00, 1'b0, 6'b000011},  // R4 nothing runs
        {1'b0, 1'b1, 2'b01, 1'b1, 6'b010000},  // R4 receive only
        {1'b0, 1'b0, 2'b10, 1'b1, 6'b010001},  // R5 duplex primary
        {1'b0, 1'b0, 2'b10, 1'b1, 6'b010100},  // R5 duplex secondary
        {1'b1, 1'b0, 2'b00, 1'b1, 6'b110100},  // R6 receive paused
        {1'b1, 1'b1, 2'b00, 1'b0, 6'b000000}   // R4 idle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {glob_en, op_mode, tx_ch_pause, rx_ch_pause}, 32'b00011);
        rd(2'd0, r); chk("R1 main reg", r, 32'h0000_0600);
        rd(2'd2, r); chk("R1 status", r, 32'h0);

        // mode table (R2..R6), R7 readback of derived bits
        for (int i = 0; i < 10; i++) begin
            wr(2'd0, {2'b00, VEC[i][5:0]});
            chk("R2-table outputs",
                {glob_en, op_mode, tx_ch_pause, rx_ch_pause},
                {VEC[i][6], VEC[i][8:7], VEC[i][9], VEC[i][10]});
            rd(2'd0, r);
            chk("R7 main readback", {r[13:8], r[5:0]},
                {VEC[i][8:7], 1'b0, VEC[i][10], VEC[i][9], VEC[i][6], VEC[i][5:0]});
        end

        // R10 fill primary, R11 overflow
        for (int i = 0; i < 17; i++) begin
            @(negedge clk); txp_push = 1'b1; txp_wdata = 32'h100 + i;
        end
        @(negedge clk); txp_push = 1'b0;
        rd(2'd2, r);
        chk("R10 full count", r[4:0], 32'd16);
        chk("R11 overflow flag", r[26:24], 32'b001);
        for (int i = 0; i < 3; i++) begin
            chk("R10 order", ser_txp_data, 32'h100 + i);
            ser_txp_pop = 1'b1; @(negedge clk); ser_txp_pop = 1'b0;
        end
        rd(2'd2, r); chk("R10 count after pops", r[4:0], 32'd13);
        chk("R11 flag sticky", r[24], 32'd1);

        // R8 secondary flush timing, R9 isolation
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); txs_push = 1'b1; txs_wdata = 32'h200 + i;
        end
        @(negedge clk); txs_push = 1'b0;
        wr(2'd1, 8'h01);
        rd(2'd2, r); chk("R8 flush not yet", r[12:8], 32'd2);
        @(negedge clk);
        rd(2'd2, r); chk("R8 flushed", r[12:8], 32'd0);
        chk("R9 primary kept", r[4:0], 32'd13);
        txs_push = 1'b1; txs_wdata = 32'h2FF; @(negedge clk); txs_push = 1'b0;
        rd(2'd2, r); chk("R8 push during flush", r[12:8], 32'd0);
        chk("R8 no flag", r[25], 32'd0);
        wr(2'd1, 8'h00);
        txs_push = 1'b1; txs_wdata = 32'h2AA; @(negedge clk); txs_push = 1'b0;
        chk("R10 sec head", ser_txs_data, 32'h2AA);

        // R8/R9 primary flush
        wr(2'd0, 8'h40);
        @(negedge clk);
        rd(2'd2, r);
        chk("R8 primary flushed", r[4:0], 32'd0);
        chk("R9 secondary kept", r[12:8], 32'd1);
        wr(2'd0, 8'h00);

        // R12 receive underflow and order
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        rd(2'd2, r);
        chk("R12 underflow", r[26], 32'd1);
        chk("R12 count", r[20:16], 32'd0);
        for (int i = 0; i < 2; i++) begin
            ser_rx_push = 1'b1; ser_rx_data = 32'h300 + i; @(negedge clk);
        end
        ser_rx_push = 1'b0;
        rd(2'd2, r); chk("R12 rx count", r[20:16], 32'd2);
        chk("R12 rx first", rx_rdata, 32'h300);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        chk("R12 rx second", rx_rdata, 32'h301);
        wr(2'd0, 8'h80);
        @(negedge clk);
        rd(2'd2, r);
        chk("R9 rx flushed", r[20:16], 32'd0);
        chk("R9 sec unaffected", r[12:8], 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule